// File: doc/BRIEF.md
# Wake and Interrupt Cause Flag Register

This block records why a low-power microcontroller woke up or was interrupted. Five event sources feed it: a pushbutton, the power-good indication from the clock PLL, the expiry of the autowake timer, a transfer-busy event and a one-second real-time tick. Each source is reduced to an edge inside the block, and each edge sets a sticky flag. The flags stay set until firmware clears them by writing a zero to the matching bit. The PLL power-good signal drives two flags: one for power returning (rising) and one for power lost, which marks entry into brownout (falling).

Firmware reads the six flags as one word. A write clears every bit that is written as zero and leaves every bit that is written as one untouched. A request to enter sleep or the LCD-only mode also clears the pushbutton flag, so that the next wake shows a fresh press. The flags are merged into three shared interrupt lines for the interrupt controller. The raw external interrupt inputs are also passed straight through, with no storage, as a debug view.

All inputs are assumed to be synchronous to `clk`. A flag changes on the clock edge at which its set or clear condition is seen.

Top module: `wake_cause_flags`

## Requirements
- R1: While reset is asserted and after it is released, all six flags and all three interrupt lines read 0.
- R2: The pushbutton flag (bit 0) sets on a rising edge of `pb_in`. Holding `pb_in` high after the flag is cleared does not set it again.
- R3: Bit 1 sets on a rising edge of `pll_ok_in`, and bit 2 sets on a falling edge of `pll_ok_in`.
- R4: A pushbutton or autowake event seen while `pll_ok_in` is low (a wake into brownout) sets only its own flag and never bit 1.
- R5: The autowake flag (bit 3), the transfer-busy flag (bit 4) and the one-second flag (bit 5) each set on a rising edge of `wake_tmr_in`, `xfer_busy_in` and `rtc_tick_in` respectively.
- R6: A cycle with `wr_en` high clears every flag whose bit in `wr_data` is 0. Bits written as 1 have no effect.
- R7: When a set event and a clear, from a write or from a mode request, fall on the same flag in the same cycle, the flag ends up set.
- R8: A cycle with `mode_req_in` high clears the pushbutton flag and leaves bits 1 to 5 unchanged.
- R9: `int_raw_out` equals `int_raw_in` in the same cycle, with no register in between.
- R10: `irq_out[0]` is bit 0 OR bit 3, `irq_out[1]` is bit 1 OR bit 2, and `irq_out[2]` is bit 4 OR bit 5, all taken from the current flag word.
- R11: A flag with no set event and no clear in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_in | input | 1 | Pushbutton level |
| pll_ok_in | input | 1 | PLL power-good level |
| wake_tmr_in | input | 1 | Autowake timer expiry level |
| xfer_busy_in | input | 1 | Transfer-busy event level |
| rtc_tick_in | input | 1 | One-second tick level |
| mode_req_in | input | 1 | Sleep or LCD-only mode request |
| wr_en | input | 1 | Firmware write strobe for the flag word |
| wr_data | input | 6 | Write data; a 0 bit clears the flag in that position |
| int_raw_in | input | 7 | External interrupt lines 0 to 6 |
| flags_out | output | 6 | Flag word: pb, power-up, power-down, autowake, transfer, tick |
| irq_out | output | 3 | Merged interrupt lines |
| int_raw_out | output | 7 | Unlatched copy of the interrupt lines |

## Verification
Two functions can act on the same flag in one cycle: a hardware set from a source edge, and a clear from a zero write or from a mode request. The bench provokes this by raising `pb_in` in the same cycle as a write of zero to bit 0. In another cycle it raises `pb_in` together with `mode_req_in`. The result is judged against a cycle-by-cycle reference model in which a set takes priority. The bench also pairs a mode request with a write that has ones in bits 1 to 5, which confirms that the automatic clear does not reach the other flags.

// File: rtl/wcf_pkg.sv
package wcf_pkg;
  localparam int NUM_FLAGS = 6;
  localparam int NUM_SRC   = 5;
  localparam int NUM_IRQ   = 3;
  localparam int NUM_INT   = 7;

  // flag word positions (software-visible)
  localparam int FLG_PB      = 0;
  localparam int FLG_PWR_UP  = 1;
  localparam int FLG_PWR_DN  = 2;
  localparam int FLG_AWAKE   = 3;
  localparam int FLG_XFER    = 4;
  localparam int FLG_TICK    = 5;

  // source vector positions (internal)
  localparam int SRC_PB    = 0;
  localparam int SRC_PWR   = 1;
  localparam int SRC_AWAKE = 2;
  localparam int SRC_XFER  = 3;
  localparam int SRC_TICK  = 4;

  // flags cleared automatically by a low-power mode request
  localparam logic [NUM_FLAGS-1:0] AUTOCLR_MASK = 6'b000001;

  // flag membership of each shared interrupt line
  localparam logic [NUM_IRQ-1:0][NUM_FLAGS-1:0] IRQ_MAP =
    {6'b110000, 6'b000110, 6'b001001};
endpackage

// File: rtl/wcf_edge_detect.sv
module wcf_edge_detect #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = lvl_i;
    rise_o = lvl_i & ~prev_q;
    fall_o = ~lvl_i & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/wcf_sticky_bit.sv
module wcf_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic auto_clr_i,
  output logic q_o
);
  logic en;
  logic d;

  always_comb begin
    en = set_i | clr_i | auto_clr_i;
    d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_o <= 1'b0;
    else if (en) q_o <= d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R7
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i || auto_clr_i) && !set_i) |=> !q_o); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && !auto_clr_i) |=> $stable(q_o)); // R11
endmodule

// File: rtl/wcf_irq_merge.sv
module wcf_irq_merge
  import wcf_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic [NUM_IRQ-1:0]   irq_o
);
  for (genvar l = 0; l < NUM_IRQ; l++) begin : g_line
    assign irq_o[l] = |(flags_i & IRQ_MAP[l]);
  end
endmodule

// File: rtl/wake_cause_flags.sv
module wake_cause_flags
  import wcf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pb_in,
  input  logic                 pll_ok_in,
  input  logic                 wake_tmr_in,
  input  logic                 xfer_busy_in,
  input  logic                 rtc_tick_in,
  input  logic                 mode_req_in,
  input  logic                 wr_en,
  input  logic [NUM_FLAGS-1:0] wr_data,
  input  logic [NUM_INT-1:0]   int_raw_in,
  output logic [NUM_FLAGS-1:0] flags_out,
  output logic [NUM_IRQ-1:0]   irq_out,
  output logic [NUM_INT-1:0]   int_raw_out
);
  logic [NUM_SRC-1:0]   src_lvl;
  logic [NUM_SRC-1:0]   src_rise;
  logic [NUM_SRC-1:0]   src_fall;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_auto;

  always_comb begin
    src_lvl            = '0;
    src_lvl[SRC_PB]    = pb_in;
    src_lvl[SRC_PWR]   = pll_ok_in;
    src_lvl[SRC_AWAKE] = wake_tmr_in;
    src_lvl[SRC_XFER]  = xfer_busy_in;
    src_lvl[SRC_TICK]  = rtc_tick_in;
  end

  wcf_edge_detect #(.W(NUM_SRC)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (src_lvl),
    .rise_o (src_rise),
    .fall_o (src_fall)
  );

  always_comb begin
    flag_set             = '0;
    flag_set[FLG_PB]     = src_rise[SRC_PB];
    flag_set[FLG_PWR_UP] = src_rise[SRC_PWR];
    flag_set[FLG_PWR_DN] = src_fall[SRC_PWR];
    flag_set[FLG_AWAKE]  = src_rise[SRC_AWAKE];
    flag_set[FLG_XFER]   = src_rise[SRC_XFER];
    flag_set[FLG_TICK]   = src_rise[SRC_TICK];
    flag_clr             = {NUM_FLAGS{wr_en}} & ~wr_data;
    flag_auto            = {NUM_FLAGS{mode_req_in}} & AUTOCLR_MASK;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    wcf_sticky_bit u_bit (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (flag_set[i]),
      .clr_i      (flag_clr[i]),
      .auto_clr_i (flag_auto[i]),
      .q_o        (flags_out[i])
    );
  end

  wcf_irq_merge u_irq (
    .flags_i (flags_out),
    .irq_o   (irq_out)
  );

  assign int_raw_out = int_raw_in;

  AST_PB_NEEDS_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_out[FLG_PB]) |-> $past(pb_in)); // R2
  AST_DOWN_NEEDS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_out[FLG_PWR_DN]) |-> !$past(pll_ok_in)); // R3
  AST_UP_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_out[FLG_PWR_UP]) |-> $past(pll_ok_in)); // R4
  AST_MODE_SPARES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req_in && !wr_en) |=>
      ((flags_out[NUM_FLAGS-1:1] & $past(flags_out[NUM_FLAGS-1:1]))
        == $past(flags_out[NUM_FLAGS-1:1]))); // R8
  AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_out == '0) |-> (irq_out == '0)); // R10
endmodule

// File: tb/wake_cause_flags_bench.sv
module wake_cause_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pb, pll, awk, xfer, tick, mode, wr_en;
  logic [5:0] wr_data;
  logic [6:0] raw_in;
  logic [5:0] flags;
  logic [2:0] irq;
  logic [6:0] raw_out;

  int total = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [5:0] m_flags;
  logic       p_pb, p_pll, p_awk, p_xfer, p_tick;

  always #2.5 clk = ~clk;

  wake_cause_flags u_wake_cause_flags (
    .clk(clk), .rst_n(rst_n), .pb_in(pb), .pll_ok_in(pll),
    .wake_tmr_in(awk), .xfer_busy_in(xfer), .rtc_tick_in(tick),
    .mode_req_in(mode), .wr_en(wr_en), .wr_data(wr_data),
    .int_raw_in(raw_in), .flags_out(flags), .irq_out(irq),
    .int_raw_out(raw_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [5:0] s;
    logic [5:0] c;
    s = 6'b0;
    if (pb && !p_pb)     s[0] = 1'b1;
    if (pll && !p_pll)   s[1] = 1'b1;
    if (!pll && p_pll)   s[2] = 1'b1;
    if (awk && !p_awk)   s[3] = 1'b1;
    if (xfer && !p_xfer) s[4] = 1'b1;
    if (tick && !p_tick) s[5] = 1'b1;
    c = wr_en ? ~wr_data : 6'b0;
    if (mode) c[0] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (s[i])      m_flags[i] = 1'b1;
      else if (c[i]) m_flags[i] = 1'b0;
    end
    p_pb = pb; p_pll = pll; p_awk = awk; p_xfer = xfer; p_tick = tick;
  endtask

  task automatic compare(input string tag);
    logic [2:0] ei;
    ei[0] = m_flags[0] | m_flags[3];
    ei[1] = m_flags[1] | m_flags[2];
    ei[2] = m_flags[4] | m_flags[5];
    check({tag, " flags"}, {10'b0, flags}, {10'b0, m_flags});
    check("R10 irq", {13'b0, irq}, {13'b0, ei});
  endtask

  // one clock: inputs already driven, model follows the edge, compare at negedge
  task automatic tick_clk(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    wr_en = 1'b0; wr_data = 6'h3F; mode = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pb = 0; pll = 0; awk = 0; xfer = 0; tick = 0;
    mode = 0; wr_en = 0; wr_data = 6'h3F; raw_in = 7'h00;
    m_flags = 6'b0; p_pb = 0; p_pll = 0; p_awk = 0; p_xfer = 0; p_tick = 0;
    repeat (3) @(negedge clk);
    check("R1 flags in reset", {10'b0, flags}, 16'h0);
    check("R1 irq in reset", {13'b0, irq}, 16'h0);
    rst_n = 1'b1;
    tick_clk("R1");

    // R9: raw mirror, combinational
    for (int k = 0; k < 4; k++) begin
      raw_in = 7'(7'h55 >> k) ^ 7'(k * 19);
      #1 check("R9 raw mirror", {9'b0, raw_out}, {9'b0, raw_in});
    end
    raw_in = 7'h7F; #1 check("R9 raw all ones", {9'b0, raw_out}, 16'h7F);
    raw_in = 7'h00; #1 check("R9 raw zero", {9'b0, raw_out}, 16'h00);

    // R2: press sets pb flag
    pb = 1; tick_clk("R2 press");
    tick_clk("R11 hold");
    wr_en = 1; wr_data = 6'b111110; tick_clk("R6 clear pb");
    tick_clk("R2 level held, no re-set");
    pb = 0; tick_clk("R2 release");

    // R3: power good rising then falling
    pll = 1; tick_clk("R3 rise");
    tick_clk("R11 hold");
    pll = 0; tick_clk("R3 fall");

    // R4: wake into brownout via pb and autowake
    pb = 1; tick_clk("R4 pb in brownout");
    pb = 0; awk = 1; tick_clk("R4 autowake in brownout");
    awk = 0; tick_clk("R4 no power-up flag");

    // R5: event sources
    xfer = 1; tick_clk("R5 xfer");
    xfer = 0; tick = 1; tick_clk("R5 tick");
    tick = 0; tick_clk("R11 idle");

    // R6: writing ones does nothing; zeros clear selected bits
    wr_en = 1; wr_data = 6'h3F; tick_clk("R6 write ones");
    wr_en = 1; wr_data = 6'b101011; tick_clk("R6 clear bits 2 and 4");
    wr_en = 1; wr_data = 6'h00; tick_clk("R6 clear all");

    // R7: set and write-clear collide
    pb = 1; wr_en = 1; wr_data = 6'b000000; tick_clk("R7 pb set vs write");
    pll = 1; wr_en = 1; wr_data = 6'b111101; tick_clk("R7 power-up set vs write");
    pb = 0; awk = 1; tick_clk("R5 autowake");

    // R8: mode request clears only pb
    awk = 0; mode = 1; tick_clk("R8 mode clears pb");
    pb = 1; tick_clk("R2 press again");
    mode = 1; wr_en = 1; wr_data = 6'h3F; tick_clk("R8 mode with ones write");
    pb = 0; tick_clk("R11 idle");
    pb = 1; mode = 1; tick_clk("R7 pb set vs mode");
    pb = 0; pll = 0; tick_clk("R3 fall again");
    wr_en = 1; wr_data = 6'h00; tick_clk("R6 final clear");

    // several mixed cycles against the model
    for (int k = 0; k < 40; k++) begin
      pb = k[0]; pll = k[2]; awk = k[1] ^ k[3]; xfer = k[3]; tick = k[4];
      mode = (k % 7) == 3;
      wr_en = (k % 5) == 2;
      wr_data = 6'(6'h2D ^ k);
      tick_clk("R11 mixed");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule